// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset and one of four 16-bit segment bases into a 20-bit physical memory address. The base is moved up four bit positions, so every segment begins on a 16-byte boundary and covers 64 KB, and the offset is added to it. Any carry above bit 19 is dropped, so addresses wrap inside the 1 MB space.

Each request carries an access kind, and the block picks a default segment from it. An optional override can replace that default, except for string-destination accesses, which are fixed to the extra segment. Requests enter on a valid/ready handshake and the address leaves one cycle later on a second valid/ready handshake, through a single register stage. A request is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being emptied in that same cycle. While the downstream side holds `out_ready` low, the pending address and its valid flag stay frozen.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals (selected segment × 16 + offset) modulo 2^20. For example, A4FBh:4872h gives A9822h and 34BAh:8AB4h gives 3D654h.
- R2: A carry out of bit 19 is discarded. FFFFh:0010h gives 00000h and FFFFh:FFFFh gives 0FFEFh.
- R3: Access kind 0 (instruction fetch) uses the code segment when no override is active.
- R4: Access kinds 1 (stack-pointer access) and 2 (base-pointer access) use the stack segment when no override is active.
- R5: Access kind 3 (general data) uses the data segment when no override is active. Unused kinds 5, 6 and 7 are treated the same way.
- R6: Access kind 4 (string destination) always uses the extra segment, and `ovr_en` has no effect on it.
- R7: For any kind other than 4, `ovr_en`=1 replaces the default with the segment coded on `ovr_sel`: 0 selects extra, 1 code, 2 stack, 3 data.
- R8: A request accepted on one edge appears with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `out_valid` and `phys_addr` hold. `in_ready` is low only while `out_valid` is high and `out_ready` is low.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The block can take a request |
| acc_kind | input | 3 | Access kind code (0 fetch, 1 stack ptr, 2 base ptr, 3 data, 4 string dest) |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment code (0 extra, 1 code, 2 stack, 3 data) |
| code_seg | input | 16 | Code segment base |
| data_seg | input | 16 | Data segment base |
| extra_seg | input | 16 | Extra segment base |
| stack_seg | input | 16 | Stack segment base |
| offset | input | 16 | Offset within segment |
| out_valid | output | 1 | An address is held on the output |
| out_ready | input | 1 | Downstream takes the address |
| phys_addr | output | 20 | Physical address |

## Verification
The four segment bases are set to distinct values, so each access kind and each override code leads to a different address. A wrong segment choice therefore shows up as a wrong address. The two worked examples check the shift-and-add. Segment and offset pairs near the top of memory separate correct wrapping from a carry that leaks into the result. The override is applied to every kind, including the string destination, which tells apart the kinds it must replace from the one it must leave alone. A later phase drops `out_ready` on a repeating pattern, which shows whether held results stay frozen and whether results arrive in order with none lost or repeated.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [2:0] {
    ACC_FETCH  = 3'd0,
    ACC_STACK  = 3'd1,
    ACC_FRAME  = 3'd2,
    ACC_DATA   = 3'd3,
    ACC_STRDST = 3'd4
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_id_e;

  localparam int NUM_SEGS  = 4;
  localparam int SEG_ID_W  = 2;
  localparam int ACC_W     = 3;
endpackage

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic [SEG_W-1:0]    seg_bank [NUM_SEGS],
  input  logic [ACC_W-1:0]    acc_kind,
  input  logic                ovr_en,
  input  logic [SEG_ID_W-1:0] ovr_sel,
  output logic [SEG_W-1:0]    seg_out
);
  seg_id_e dflt_id;
  seg_id_e eff_id;

  always_comb begin
    case (acc_kind)
      ACC_FETCH:  dflt_id = SEG_CODE;
      ACC_STACK,
      ACC_FRAME:  dflt_id = SEG_STACK;
      ACC_STRDST: dflt_id = SEG_EXTRA;
      default:    dflt_id = SEG_DATA;
    endcase
  end

  always_comb begin
    if (ovr_en && (acc_kind != ACC_STRDST)) eff_id = seg_id_e'(ovr_sel);
    else                                    eff_id = dflt_id;
  end

  assign seg_out = seg_bank[eff_id];
endmodule

// File: rtl/addr_sum.sv
module addr_sum #(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = 20
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFS_W-1:0] ofs,
  output logic [PA_W-1:0]  addr
);
  localparam int BASE_W = SEG_W + SHIFT;

  logic [BASE_W-1:0] base_full;
  logic [PA_W-1:0]   base_w;
  logic [PA_W-1:0]   ofs_w;

  assign base_full = {seg, {SHIFT{1'b0}}};
  assign base_w    = PA_W'(base_full);
  assign ofs_w     = PA_W'(ofs);
  assign addr      = base_w + ofs_w;
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         valid_q;
  logic [W-1:0] data_q;

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [ACC_W-1:0]    acc_kind,
  input  logic                ovr_en,
  input  logic [SEG_ID_W-1:0] ovr_sel,
  input  logic [SEG_W-1:0]    code_seg,
  input  logic [SEG_W-1:0]    data_seg,
  input  logic [SEG_W-1:0]    extra_seg,
  input  logic [SEG_W-1:0]    stack_seg,
  input  logic [OFS_W-1:0]    offset,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [PA_W-1:0]     phys_addr
);
  logic [SEG_W-1:0] bank [NUM_SEGS];
  logic [SEG_W-1:0] chosen_seg;
  logic [PA_W-1:0]  sum_addr;

  assign bank[SEG_EXTRA] = extra_seg;
  assign bank[SEG_CODE]  = code_seg;
  assign bank[SEG_STACK] = stack_seg;
  assign bank[SEG_DATA]  = data_seg;

  seg_select #(.SEG_W(SEG_W)) u_sel (
    .seg_bank (bank),
    .acc_kind (acc_kind),
    .ovr_en   (ovr_en),
    .ovr_sel  (ovr_sel),
    .seg_out  (chosen_seg)
  );

  addr_sum #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_sum (
    .seg  (chosen_seg),
    .ofs  (offset),
    .addr (sum_addr)
  );

  out_stage #(.W(PA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (sum_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (phys_addr)
  );
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       acc_kind,
  input logic             ovr_en,
  input logic [SEG_W-1:0] code_seg,
  input logic [SEG_W-1:0] extra_seg,
  input logic [OFS_W-1:0] offset,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PA_W-1:0]  phys_addr
);
  logic take;
  assign take = in_valid && in_ready;

  // R9: first cycle out of reset has nothing pending
  a_r9_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !out_valid);

  // R8: an accepted request shows up after the edge
  a_r8_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(take)) |-> out_valid);

  // R8: stalled result is frozen
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(phys_addr)));

  // R3: fetch without override lands in the code segment
  a_r3_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
    (take && acc_kind == 3'd0 && !ovr_en) |=>
      phys_addr == $past(PA_W'({code_seg, {SHIFT{1'b0}}}) + PA_W'(offset)));

  // R6: string destination always lands in the extra segment
  a_r6_strdst_extra: assert property (@(posedge clk) disable iff (!rst_n)
    (take && acc_kind == 3'd4) |=>
      phys_addr == $past(PA_W'({extra_seg, {SHIFT{1'b0}}}) + PA_W'(offset)));
endmodule

bind seg_addr_gen seg_addr_chk #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .acc_kind  (acc_kind),
  .ovr_en    (ovr_en),
  .code_seg  (code_seg),
  .extra_seg (extra_seg),
  .offset    (offset),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .phys_addr (phys_addr)
);

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  acc_kind = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic [15:0] code_seg = 16'h1234;
  logic [15:0] data_seg = 16'hA4FB;
  logic [15:0] extra_seg = 16'h5678;
  logic [15:0] stack_seg = 16'h9ABC;
  logic [15:0] offset = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] phys_addr;

  int n_tests = 0;
  int n_fail  = 0;
  int n_sent  = 0;
  int n_recv  = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  typedef struct { logic [19:0] addr; string req; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  seg_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .acc_kind(acc_kind), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .code_seg(code_seg), .data_seg(data_seg), .extra_seg(extra_seg),
    .stack_seg(stack_seg), .offset(offset), .out_valid(out_valid),
    .out_ready(out_ready), .phys_addr(phys_addr)
  );

  function automatic logic [15:0] pick_seg(input logic [2:0] k, input logic oe,
                                           input logic [1:0] os);
    logic [1:0] id;
    if (k == 3'd4) return extra_seg;
    if (oe) id = os;
    else if (k == 3'd0) id = 2'd1;
    else if (k == 3'd1 || k == 3'd2) id = 2'd2;
    else id = 2'd3;
    case (id)
      2'd0: return extra_seg;
      2'd1: return code_seg;
      2'd2: return stack_seg;
      default: return data_seg;
    endcase
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: offers one request, pushes the expected address
  task automatic send(input string req, input logic [2:0] k, input logic oe,
                      input logic [1:0] os, input logic [15:0] o);
    exp_t e;
    @(negedge clk);
    acc_kind = k; ovr_en = oe; ovr_sel = os; offset = o; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    e.addr = phys(pick_seg(k, oe, os), o);
    e.req  = req;
    exp_q.push_back(e);
    n_sent++;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // monitor: pops on each transfer
  logic [19:0] held_addr;
  bit          held = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        check("R8 hold valid", {31'd0, out_valid}, 32'd1);
        check("R8 hold addr", {12'd0, phys_addr}, {12'd0, held_addr});
        check("R8 in_ready low while stalled", {31'd0, in_ready}, {31'd0, out_ready});
      end
      held = out_valid && !out_ready;
      held_addr = phys_addr;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected output", {12'd0, phys_addr}, 32'hFFFFFFFF);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.req, {12'd0, phys_addr}, {12'd0, e.addr});
          n_recv++;
        end
      end
    end
  end

  // back-pressure pattern, changed away from sampling points
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    out_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  initial begin
    #40000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R9 in_ready after reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid idle", {31'd0, out_valid}, 32'd0);

    // R1 worked examples via data segment
    data_seg = 16'hA4FB;
    send("R1 A4FB:4872", 3'd3, 1'b0, 2'd0, 16'h4872);
    @(negedge clk); data_seg = 16'h34BA;
    send("R1 34BA:8AB4", 3'd3, 1'b0, 2'd0, 16'h8AB4);
    @(negedge clk); data_seg = 16'hFFFF;
    send("R2 wrap FFFF:0010", 3'd3, 1'b0, 2'd0, 16'h0010);
    send("R2 wrap FFFF:FFFF", 3'd3, 1'b0, 2'd0, 16'hFFFF);
    @(negedge clk); data_seg = 16'hA4FB;
    send("R3 fetch code", 3'd0, 1'b0, 2'd0, 16'h0100);
    send("R4 stack ptr", 3'd1, 1'b0, 2'd0, 16'hFFFE);
    send("R4 base ptr", 3'd2, 1'b0, 2'd0, 16'h0020);
    send("R5 data", 3'd3, 1'b0, 2'd0, 16'h0004);
    send("R5 unused kind 5", 3'd5, 1'b0, 2'd0, 16'h0005);
    send("R5 unused kind 6", 3'd6, 1'b0, 2'd0, 16'h0006);
    send("R5 unused kind 7", 3'd7, 1'b0, 2'd0, 16'h0007);
    send("R6 string dest", 3'd4, 1'b0, 2'd0, 16'h0040);
    for (int s = 0; s < 4; s++) begin
      send("R6 string dest ignores override", 3'd4, 1'b1, 2'(s), 16'h1111);
      for (int k = 0; k < 4; k++)
        send("R7 override", 3'(k), 1'b1, 2'(s), 16'(16'h0300 + k));
    end

    // R8 back-pressure phase
    stall_mode = 1'b1;
    for (int i = 0; i < 30; i++)
      send("R8 stalled stream", 3'(i % 8), i[0], 2'(i % 4), 16'(i * 16'h0777));
    repeat (10) @(negedge clk);
    stall_mode = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 all results delivered", 32'(n_recv), 32'(n_sent));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule